// File: doc/BRIEF.md
# SPI Burst Register-Access Master

This block is the host side of a serial link to a peripheral whose registers are grouped into pages. A single request names the direction, a page, a register address and a word count. The block pulls chip select low and shifts out a 16-bit command word. It then moves the requested number of 16-bit data words and only after that releases chip select. Write data arrives on its own valid/ready stream, one word per data word. Read results leave on a valid/ready result stream that holds one word. The serial clock is derived from the system clock through a divider. The divider setting can only be changed while the block is disabled.

All three streams follow the same rule: a transfer happens on a rising clock edge where both valid and ready are high. The block applies back-pressure by pausing between serial words. The serial clock stays low and chip select stays low until the next word can go. A read word does not start while the previous result is still waiting. A write word does not start until its data is offered. The request stream is ready only when the block is enabled and idle. The enable and divider pins are plain control inputs, and `busy` is a plain status output.

Top module: `spi_regburst_master`

## Requirements
- R1: The command word is 16 bits. Bit 15 is 1 for a read and 0 for a write. Bits 14:11 carry the page, bits 10:5 the register address, and bits 4:0 are zero. Every word is shifted most significant bit first.
- R2: `sclk` idles low. `mosi` changes only when `sclk` rises, and `miso` is sampled when `sclk` falls. A word takes 16 rising and 16 falling edges.
- R3: Each half period of `sclk` lasts DIV system clocks. DIV resets to 6, and a setting of 0 acts as 1. A `cfg_div_wr` pulse loads `cfg_div` only while `enable` is low; it is ignored while enabled.
- R4: `cs_n` falls when a request is accepted. It stays low through the command word and all data words, and rises only after the final falling `sclk` edge.
- R5: The word count field is 5 bits. A count of 0 moves one data word, and counts above 16 move 16.
- R6: A read transmits all-zero data words. Each word received during a data word is delivered, in order, on the result stream. The word received during the command word is never delivered.
- R7: A write transmits the write-stream words in order. Received words are discarded, so no result is produced.
- R8: `busy` is high from the accepting edge until `cs_n` rises. `req_ready` is never high while `busy` is high.
- R9: After `cs_n` rises, no new request is accepted for two half periods (2*DIV clocks), so `cs_n` stays high for at least one full `sclk` period.
- R10: With a result unaccepted, the next read word does not start. `sclk` holds low with `cs_n` low, and the held result is not overwritten.
- R11: When `enable` is low, `cs_n` is high and `sclk` is low from the next clock on. An active transaction is abandoned, `busy` drops and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low forces the link idle |
| cfg_div_wr | input | 1 | Load strobe for the divider setting (honoured only while disabled) |
| cfg_div | input | DIV_W | New divider setting (half period in system clocks) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write transaction, 0 = read |
| req_page | input | 4 | Register page |
| req_addr | input | 6 | Register address within the page |
| req_count | input | CNT_W | Number of data words (0 acts as 1, capped at 16) |
| wdata_valid | input | 1 | Write word offered |
| wdata_ready | output | 1 | Write word accepted when high with wdata_valid |
| wdata | input | 16 | Write word |
| rd_valid | output | 1 | Result word available |
| rd_ready | input | 1 | Consumer takes the result |
| rd_data | output | 16 | Result word |
| busy | output | 1 | Transaction in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |
| cs_n | output | 1 | Active-low chip select |

## Verification
A corrupted shift register or bit counter shows up at the serial pins within one word. The command or data words seen by the peripheral model come out wrong, or the count of `sclk` edges per transaction differs from 16 times the number of words. A wrong sequencer state shows as `cs_n` rising early or late, a missing or extra result, or `req_ready` rising while `busy` is high, and this becomes visible by the end of the same transaction. A divider fault changes the measured high time of `sclk` on its first pulse. A broken enable path leaves `cs_n` low or `sclk` high one clock after `enable` falls.

// File: rtl/spi_regburst_pkg.sv
package spi_regburst_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned PAGE_W = 4;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned PAD_W  = WORD_W - 1 - PAGE_W - ADDR_W;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_GAP,
    SQ_SHIFT,
    SQ_TAIL,
    SQ_HOLD
  } seq_state_t;

  // direction flag on top, then page, address and zero padding
  function automatic logic [WORD_W-1:0] build_cmd(
    input logic              is_read,
    input logic [PAGE_W-1:0] page,
    input logic [ADDR_W-1:0] addr
  );
    return {is_read, page, addr, {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/spi_halfper_timer.sv
module spi_halfper_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  assign limit = (div == '0) ? DIV_W'(1) : div;
  assign tick  = run && (cnt == limit - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                  cnt <= cnt + DIV_W'(1);
  end

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < limit));
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         abort,
  input  logic         start,
  input  logic [W-1:0] tx_word,
  input  logic         tick,
  input  logic         miso,
  output logic         sclk,
  output logic         mosi,
  output logic         done,
  output logic         active,
  output logic [W-1:0] rx_word
);
  localparam int unsigned EDGES = 2 * W;
  localparam int unsigned EC_W  = $clog2(EDGES);

  logic [EC_W-1:0] edge_cnt;
  logic [W-1:0]    tx_sr;
  logic [W-1:0]    rx_sr;

  assign rx_word = rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      done     <= 1'b0;
      active   <= 1'b0;
      edge_cnt <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        active <= 1'b0;
        sclk   <= 1'b0;
      end else if (start) begin
        active   <= 1'b1;
        tx_sr    <= tx_word;
        edge_cnt <= '0;
        sclk     <= 1'b0;
      end else if (active && tick) begin
        edge_cnt <= edge_cnt + EC_W'(1);
        if (!sclk) begin
          sclk  <= 1'b1;
          mosi  <= tx_sr[W-1];
          tx_sr <= {tx_sr[W-2:0], 1'b0};
        end else begin
          sclk  <= 1'b0;
          rx_sr <= {rx_sr[W-2:0], miso};
          if (edge_cnt == EC_W'(EDGES - 1)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end
      end
    end
  end

  // R2
  mosi_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(mosi) |-> $rose(sclk));
  // R2
  sclk_in_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> active);
  // R10
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);
endmodule

// File: rtl/spi_txn_seq.sv
module spi_txn_seq
  import spi_regburst_pkg::*;
#(
  parameter int unsigned MAX_WORDS = 16,
  parameter int unsigned CNT_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              wdata_valid,
  output logic              wdata_ready,
  input  logic [WORD_W-1:0] wdata,
  input  logic              res_free,
  input  logic              tick,
  input  logic              sh_done,
  output logic              timer_run,
  output logic              sh_start,
  output logic [WORD_W-1:0] sh_tx,
  output logic              res_load,
  output logic              cs_n,
  output logic              busy
);
  seq_state_t        state;
  logic              is_wr;
  logic              cmd_pend;
  logic              hold_second;
  logic [WORD_W-1:0] cmd_word;
  logic [CNT_W-1:0]  remaining;
  logic [CNT_W-1:0]  cnt_eff;
  logic              accept, go_cmd, go_rd, go_wr;

  assign cnt_eff = (req_count == '0)                ? CNT_W'(1) :
                   (req_count > CNT_W'(MAX_WORDS))  ? CNT_W'(MAX_WORDS) : req_count;

  assign req_ready   = enable && (state == SQ_IDLE);
  assign accept      = req_valid && req_ready;
  assign wdata_ready = enable && (state == SQ_GAP) && !cmd_pend && is_wr;
  assign go_cmd      = enable && (state == SQ_GAP) && cmd_pend;
  assign go_rd       = enable && (state == SQ_GAP) && !cmd_pend && !is_wr && res_free;
  assign go_wr       = wdata_valid && wdata_ready;
  assign sh_start    = go_cmd || go_rd || go_wr;
  assign sh_tx       = go_cmd ? cmd_word : (go_wr ? wdata : '0);
  assign res_load    = (state == SQ_SHIFT) && sh_done && !cmd_pend && !is_wr;
  assign timer_run   = (state == SQ_SHIFT) || (state == SQ_TAIL) || (state == SQ_HOLD);
  assign busy        = (state != SQ_IDLE) && (state != SQ_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SQ_IDLE;
      cs_n        <= 1'b1;
      is_wr       <= 1'b0;
      cmd_pend    <= 1'b0;
      hold_second <= 1'b0;
      cmd_word    <= '0;
      remaining   <= '0;
    end else if (!enable) begin
      state <= SQ_IDLE;
      cs_n  <= 1'b1;
    end else begin
      case (state)
        SQ_IDLE: if (accept) begin
          cs_n      <= 1'b0;
          is_wr     <= req_write;
          cmd_word  <= build_cmd(!req_write, req_page, req_addr);
          remaining <= cnt_eff;
          cmd_pend  <= 1'b1;
          state     <= SQ_GAP;
        end
        SQ_GAP: if (sh_start) state <= SQ_SHIFT;
        SQ_SHIFT: if (sh_done) begin
          if (cmd_pend) begin
            cmd_pend <= 1'b0;
            state    <= SQ_GAP;
          end else if (remaining == CNT_W'(1)) begin
            state <= SQ_TAIL;
          end else begin
            remaining <= remaining - CNT_W'(1);
            state     <= SQ_GAP;
          end
        end
        SQ_TAIL: if (tick) begin
          cs_n        <= 1'b1;
          hold_second <= 1'b0;
          state       <= SQ_HOLD;
        end
        SQ_HOLD: if (tick) begin
          if (hold_second) state <= SQ_IDLE;
          else             hold_second <= 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R8
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  // R4
  cs_low_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_SHIFT) |-> !cs_n);
  // R9
  cs_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> !req_ready);
endmodule

// File: rtl/spi_regburst_master.sv
module spi_regburst_master
  import spi_regburst_pkg::*;
#(
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned DIV_RESET = 6,
  parameter int unsigned MAX_WORDS = 16,
  parameter int unsigned CNT_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_div_wr,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              wdata_valid,
  output logic              wdata_ready,
  input  logic [WORD_W-1:0] wdata,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  logic [DIV_W-1:0]  div_q;
  logic              tick, timer_run;
  logic              sh_start, sh_done, sh_active;
  logic [WORD_W-1:0] sh_tx, sh_rx;
  logic              res_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     div_q <= DIV_W'(DIV_RESET);
    else if (cfg_div_wr && !enable) div_q <= cfg_div;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (res_load) begin
      rd_valid <= 1'b1;
      rd_data  <= sh_rx;
    end else if (rd_valid && rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  spi_halfper_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(timer_run), .div(div_q), .tick(tick)
  );

  spi_word_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .abort(!enable), .start(sh_start),
    .tx_word(sh_tx), .tick(tick), .miso(miso), .sclk(sclk), .mosi(mosi),
    .done(sh_done), .active(sh_active), .rx_word(sh_rx)
  );

  spi_txn_seq #(.MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_page(req_page), .req_addr(req_addr), .req_count(req_count),
    .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .wdata(wdata),
    .res_free(!rd_valid), .tick(tick), .sh_done(sh_done),
    .timer_run(timer_run), .sh_start(sh_start), .sh_tx(sh_tx),
    .res_load(res_load), .cs_n(cs_n), .busy(busy)
  );

  // R11
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cs_n && !sclk));
  // R4
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (!sclk && !sh_active));
  // R4
  sclk_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !cs_n);
  // R10
  result_no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_load |-> !rd_valid);
  // R3
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> $stable(div_q));
endmodule

// File: tb/spi_regburst_master_bench.sv
module spi_regburst_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cfg_div_wr = 1'b0;
  logic [7:0]  cfg_div = 8'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_page = 4'd0;
  logic [5:0]  req_addr = 6'd0;
  logic [4:0]  req_count = 5'd0;
  logic        wdata_valid = 1'b0;
  logic        wdata_ready;
  logic [15:0] wdata = 16'd0;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [15:0] rd_data;
  logic        busy, sclk, mosi, cs_n;
  logic        miso = 1'b0;

  always #4 clk = ~clk;

  spi_regburst_master u_spi_regburst_master (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_div_wr(cfg_div_wr),
    .cfg_div(cfg_div), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_page(req_page), .req_addr(req_addr),
    .req_count(req_count), .wdata_valid(wdata_valid), .wdata_ready(wdata_ready),
    .wdata(wdata), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int total = 0;
  int fails = 0;
  int cyc = 0;

  // peripheral model and monitor, sampled on falling clk
  logic [15:0] tx_mem [64];
  logic [15:0] mosi_mem [64];
  logic [15:0] res_log [64];
  logic [15:0] wr_words [16];
  logic [15:0] mosi_sr = 16'd0;
  int n_rise = 0, n_fall = 0, n_res = 0;
  int hi_len = 0, last_hi = 0, cs_hi = 0, last_gap = 0, viol = 0;
  logic sclk_q = 1'b0, cs_q = 1'b1;

  always @(negedge clk) begin
    if (sclk && !sclk_q) begin
      miso = tx_mem[(n_rise >> 4) & 63][15 - (n_rise & 15)];
      n_rise++;
    end
    if (sclk) hi_len++;
    if (!sclk && sclk_q) begin
      last_hi = hi_len;
      hi_len  = 0;
      mosi_sr = {mosi_sr[14:0], mosi};
      if ((n_fall & 15) == 15) mosi_mem[(n_fall >> 4) & 63] = mosi_sr;
      n_fall++;
    end
    if (cs_n) cs_hi++;
    if (!cs_n && cs_q) begin
      last_gap = cs_hi;
      cs_hi    = 0;
    end
    if (busy && req_ready) viol++;
    if (rd_valid && rd_ready) begin
      res_log[n_res & 63] = rd_data;
      n_res++;
    end
    sclk_q = sclk;
    cs_q   = cs_n;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cmd_of(input bit wr, input logic [3:0] pg, input logic [5:0] ad);
    return {~wr, pg, ad, 5'b00000};
  endfunction

  function automatic logic [15:0] pat(input int seed, input int i);
    return 16'hA5C3 ^ 16'(seed * 16'h0101) ^ 16'(i * 16'h1357);
  endfunction

  task automatic send_req(input bit wr, input logic [3:0] pg, input logic [5:0] ad, input logic [4:0] cnt);
    req_write = wr; req_page = pg; req_addr = ad; req_count = cnt; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic push_w(input logic [15:0] w);
    wdata = w; wdata_valid = 1'b1;
    while (!wdata_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    wdata_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic prep_read(input int seed, input int nw);
    int bw;
    bw = n_rise >> 4;
    tx_mem[bw & 63] = 16'hDEAD;
    for (int i = 0; i < nw; i++) tx_mem[(bw + 1 + i) & 63] = pat(seed, i);
  endtask

  task automatic set_div(input logic [7:0] d);
    enable = 1'b0;
    @(negedge clk);
    cfg_div = d; cfg_div_wr = 1'b1;
    @(negedge clk);
    cfg_div_wr = 1'b0; enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(cs_n && !sclk && !busy && !rd_valid && !req_ready, "R11 reset idle",
        {cs_n, sclk, busy, rd_valid, req_ready}, 5'b10000);
  endtask

  task automatic t_write();
    int bf, br, bres;
    bf = n_fall; br = n_rise; bres = n_res;
    wr_words[0] = 16'h8001; wr_words[1] = 16'h7E3C; wr_words[2] = 16'h00FF;
    send_req(1'b1, 4'h3, 6'h15, 5'd3);
    chk(busy && !cs_n && !req_ready, "R8 busy after accept", {busy, cs_n, req_ready}, 3'b100);
    for (int i = 0; i < 3; i++) push_w(wr_words[i]);
    wait_idle();
    chk(mosi_mem[(bf >> 4) & 63] == cmd_of(1'b1, 4'h3, 6'h15), "R1 write command",
        mosi_mem[(bf >> 4) & 63], cmd_of(1'b1, 4'h3, 6'h15));
    for (int i = 0; i < 3; i++)
      chk(mosi_mem[((bf >> 4) + 1 + i) & 63] == wr_words[i], "R7 write data word",
          mosi_mem[((bf >> 4) + 1 + i) & 63], wr_words[i]);
    chk(n_res == bres, "R7 no result on write", n_res - bres, 0);
    chk(n_rise - br == 64, "R4 edges under one select", n_rise - br, 64);
    chk(last_hi == 6, "R3 reset half period", last_hi, 6);
    chk(viol == 0, "R8 ready while busy", viol, 0);
  endtask

  task automatic t_read();
    int bf, bres;
    bf = n_fall; bres = n_res;
    prep_read(1, 4);
    send_req(1'b0, 4'hA, 6'h2C, 5'd4);
    wait_idle();
    chk(mosi_mem[(bf >> 4) & 63] == cmd_of(1'b0, 4'hA, 6'h2C), "R1 read command",
        mosi_mem[(bf >> 4) & 63], cmd_of(1'b0, 4'hA, 6'h2C));
    chk(n_res - bres == 4, "R6 result count", n_res - bres, 4);
    for (int i = 0; i < 4; i++) begin
      chk(res_log[(bres + i) & 63] == pat(1, i), "R6 read result",
          res_log[(bres + i) & 63], pat(1, i));
      chk(mosi_mem[((bf >> 4) + 1 + i) & 63] == 16'h0000, "R6 zero fill",
          mosi_mem[((bf >> 4) + 1 + i) & 63], 0);
    end
  endtask

  task automatic t_counts();
    int br, bres;
    br = n_rise;
    send_req(1'b1, 4'h1, 6'h01, 5'd0);
    push_w(16'h1234);
    wait_idle();
    chk(n_rise - br == 32, "R5 count zero moves one word", n_rise - br, 32);
    br = n_rise; bres = n_res;
    prep_read(2, 16);
    send_req(1'b0, 4'h2, 6'h02, 5'd20);
    wait_idle();
    chk(n_rise - br == 17 * 16, "R5 count capped edges", n_rise - br, 17 * 16);
    chk(n_res - bres == 16, "R5 count capped results", n_res - bres, 16);
    chk(res_log[(bres + 15) & 63] == pat(2, 15), "R5 last capped word",
        res_log[(bres + 15) & 63], pat(2, 15));
  endtask

  task automatic t_backpressure();
    int br, bres;
    br = n_rise; bres = n_res;
    rd_ready = 1'b0;
    prep_read(3, 3);
    send_req(1'b0, 4'h5, 6'h0A, 5'd3);
    repeat (64 * 6 + 150) @(negedge clk);
    chk(n_rise - br == 32, "R10 stalled edges", n_rise - br, 32);
    chk(rd_valid && rd_data == pat(3, 0), "R10 held result", rd_data, pat(3, 0));
    chk(!cs_n == 1'b1 && !sclk && busy, "R10 link paused", {cs_n, sclk, busy}, 3'b001);
    rd_ready = 1'b1;
    wait_idle();
    chk(n_res - bres == 3, "R10 results after release", n_res - bres, 3);
    chk(res_log[(bres + 2) & 63] == pat(3, 2), "R10 last result",
        res_log[(bres + 2) & 63], pat(3, 2));
  endtask

  task automatic t_gap(input int d);
    send_req(1'b1, 4'h6, 6'h06, 5'd1);
    push_w(16'h0F0F);
    send_req(1'b1, 4'h7, 6'h07, 5'd1);
    push_w(16'hF0F0);
    wait_idle();
    chk(last_gap >= 2 * d, "R9 select high gap", last_gap, 2 * d);
  endtask

  task automatic t_div();
    set_div(8'd2);
    @(negedge clk);
    cfg_div = 8'd9; cfg_div_wr = 1'b1;
    @(negedge clk);
    cfg_div_wr = 1'b0;
    send_req(1'b1, 4'h0, 6'h00, 5'd1);
    push_w(16'h5555);
    wait_idle();
    chk(last_hi == 2, "R3 divider 2, write while enabled ignored", last_hi, 2);
    t_gap(2);
    set_div(8'd0);
    send_req(1'b1, 4'h0, 6'h00, 5'd1);
    push_w(16'hAAAA);
    wait_idle();
    chk(last_hi == 1, "R3 divider zero acts as one", last_hi, 1);
  endtask

  task automatic t_disable();
    prep_read(4, 16);
    send_req(1'b0, 4'h9, 6'h09, 5'd16);
    repeat (40) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(cs_n && !sclk && !busy && !req_ready, "R11 disable mid transaction",
        {cs_n, sclk, busy, req_ready}, 4'b1000);
    repeat (10) @(negedge clk);
    chk(cs_n && !sclk, "R11 stays idle while disabled", {cs_n, sclk}, 2'b10);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      tx_mem[i] = 16'h0; mosi_mem[i] = 16'h0; res_log[i] = 16'h0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    enable = 1'b1;
    @(negedge clk);
    t_write();
    t_read();
    t_counts();
    t_backpressure();
    t_gap(6);
    t_div();
    t_disable();
    summary();
  end
endmodule